// File: doc/BRIEF.md
# XNOR LFSR Counter with Programmable Period

This block is a linear feedback shift register that closes its loop through an XNOR of a fixed set of tap bits. Because the feedback is XNOR rather than XOR, the all-zero word is a normal member of the cycle and serves as the start value. The all-ones word is the one pattern the loop cannot leave, so it must never appear. The tap set is picked at elaboration from the `WIDTH` parameter, and each supported tap set gives a period of 2^N−1. The block can be used as a pseudorandom source, or as a counter or divider whose only logic between flops is one small XNOR gate.

A terminal-value input shortens the period. When the register equals `term_val` on an enabled clock, the next state is zero, not the shifted value. The period then becomes the position of `term_val` in the natural sequence plus one. The `wrap` output marks every cycle whose next state is zero, whether that zero comes from a terminal match or from the natural return of the sequence. A per-cycle step selector picks one of three named actions:
- `STEP_HOLD`: enable low, keep the state.
- `STEP_SHIFT`: shift in the feedback bit.
- `STEP_RELOAD`: terminal match, load zero.

Top module: `xnor_lfsr_counter`

## Requirements
- R1: An active-low asynchronous reset forces `state_q` to zero. While `en` is low, `wrap` stays low.
- R2: On each enabled step with no terminal match, the register shifts toward its MSB and the XNOR of its tap bits enters bit 0. For WIDTH=4 the taps are bits 3 and 2, and the sequence from zero is 0,1,3,7,E,D,B,6,C,9,2,5,A,4,8 and then 0.
- R3: The zero-based tap bits are {7,5,4,3} for WIDTH=8, {15,14,12,3} for WIDTH=16 and {31,21,1,0} for WIDTH=32. With `term_val` all-ones, the first return to zero comes after exactly 2^N−1 enabled steps.
- R4: With `en` low the state holds its value and `wrap` is low.
- R5: When `state_q` equals `term_val` on an enabled clock, the next state is zero. With WIDTH=4 and `term_val`=6, the period is 8.
- R6: `wrap` is high in exactly those enabled cycles whose next state is zero, by reload or by natural return. It is decoded from the current state, in the same cycle.
- R7: Starting from reset, the all-ones state is never reached.
- R8: With `term_val` equal to zero, the state remains zero and `wrap` is high on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Step enable |
| term_val | input | WIDTH | State at which the sequence reloads zero |
| state_q | output | WIDTH | Current register state |
| wrap | output | 1 | High when the next state will be zero |

## Verification
The assertions assume that `state_q` only ever holds values reached from reset through enabled steps. Under that assumption the lock-up pattern can never occur. The stimulus keeps to this by always reloading through reset, never forcing state, and by changing `term_val` only while reset is held. Each assertion that checks enable also assumes that `en` and `term_val` are stable at the clock edge. The bench drives them only on falling edges.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_SHIFT  = 2'd1,
        STEP_RELOAD = 2'd2
    } step_e;

    // Tap bit mask (zero-based bit positions) per supported width.
    function automatic logic [31:0] tap_mask(input int unsigned w);
        logic [31:0] m;
        case (w)
            4:       m = 32'h0000_000C; // bits 3,2
            8:       m = 32'h0000_00B8; // bits 7,5,4,3
            16:      m = 32'h0000_D008; // bits 15,14,12,3
            32:      m = 32'h8020_0003; // bits 31,21,1,0
            default: m = 32'h0000_0000;
        endcase
        return m;
    endfunction

    function automatic bit width_ok(input int unsigned w);
        return (w == 4) || (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
    import lfsr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    output logic             fb
);
    localparam logic [31:0] MASK_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] MASK = MASK_FULL[WIDTH-1:0];

    generate
        if (!width_ok(WIDTH)) begin : g_bad_width
            $error("lfsr_feedback: unsupported WIDTH");
        end
    endgenerate

    // Single reduction XNOR over the selected taps
    assign fb = ~^(q & MASK);

endmodule

// File: rtl/lfsr_term_match.sv
module lfsr_term_match #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] term,
    output logic             hit
);
    assign hit = (q == term);
endmodule

// File: rtl/xnor_lfsr_counter.sv
module xnor_lfsr_counter
    import lfsr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] term_val,
    output logic [WIDTH-1:0] state_q,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] ZERO_ST = '0;
    localparam logic [WIDTH-1:0] LOCK_ST = '1;

    logic             fb;
    logic             hit;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] state_d;
    step_e            step;

    lfsr_feedback #(.WIDTH(WIDTH)) u_fb (
        .q  (state_q),
        .fb (fb)
    );

    lfsr_term_match #(.WIDTH(WIDTH)) u_term (
        .q    (state_q),
        .term (term_val),
        .hit  (hit)
    );

    assign shifted = {state_q[WIDTH-2:0], fb};

    // Step selection: hold, shift, or reload zero on terminal match
    always_comb begin
        if (!en)      step = STEP_HOLD;
        else if (hit) step = STEP_RELOAD;
        else          step = STEP_SHIFT;
    end

    always_comb begin
        unique case (step)
            STEP_HOLD:   state_d = state_q;
            STEP_SHIFT:  state_d = shifted;
            STEP_RELOAD: state_d = ZERO_ST;
            default:     state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ZERO_ST;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (step)
            STEP_HOLD:   wrap = 1'b0;
            STEP_SHIFT:  wrap = (shifted == ZERO_ST);
            STEP_RELOAD: wrap = 1'b1;
            default:     wrap = 1'b0;
        endcase
    end

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));

    // R5
    term_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == term_val) |=> (state_q == ZERO_ST));

    // R7
    no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != LOCK_ST);

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (state_q == ZERO_ST));

    // R6
    nowrap_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wrap) |=> (state_q != ZERO_ST));

    // R4
    hold_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !wrap);

endmodule

// File: tb/sim_xnor_lfsr_counter.sv
`timescale 1ns/1ps
module sim_xnor_lfsr_counter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en4, en8, en16;
    logic [3:0]  term4, q4;
    logic [7:0]  term8, q8;
    logic [15:0] term16, q16;
    logic        wrap4, wrap8, wrap16;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [3:0] seq4 [0:14];

    always #4 clk = ~clk;

    xnor_lfsr_counter #(.WIDTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en4), .term_val(term4),
        .state_q(q4), .wrap(wrap4)
    );
    xnor_lfsr_counter #(.WIDTH(8)) u8 (
        .clk(clk), .rst_n(rst_n), .en(en8), .term_val(term8),
        .state_q(q8), .wrap(wrap8)
    );
    xnor_lfsr_counter #(.WIDTH(16)) u16 (
        .clk(clk), .rst_n(rst_n), .en(en16), .term_val(term16),
        .state_q(q16), .wrap(wrap16)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        int first0_8, first0_16, wrap8_at, wrap16_at, ones;
        logic [3:0] held;
        seq4 = '{4'h0, 4'h1, 4'h3, 4'h7, 4'hE, 4'hD, 4'hB, 4'h6,
                 4'hC, 4'h9, 4'h2, 4'h5, 4'hA, 4'h4, 4'h8};
        rst_n = 1'b0; en4 = 1'b0; en8 = 1'b0; en16 = 1'b0;
        term4 = 4'hF; term8 = 8'hFF; term16 = 16'hFFFF;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset state", 32'(q4), 32'h0);
        check("R1 wrap low", 32'(wrap4), 32'h0);

        // R2 natural sequence, two full laps
        @(negedge clk);
        rst_n = 1'b1; en4 = 1'b1;
        for (int i = 0; i < 32; i++) begin
            #1;
            check("R2 sequence", 32'(q4), 32'(seq4[i % 15]));
            check("R6 wrap natural", 32'(wrap4), 32'(i % 15 == 14));
            @(negedge clk);
        end

        // R4 hold
        en4 = 1'b0;
        #1 held = q4;
        repeat (5) begin
            @(negedge clk); #1;
            check("R4 hold state", 32'(q4), 32'(held));
            check("R4 hold no wrap", 32'(wrap4), 32'h0);
        end

        // R5 shortened period, terminal 6
        rst_n = 1'b0; term4 = 4'h6; en4 = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 24; i++) begin
            #1;
            check("R5 short period", 32'(q4), 32'(seq4[i % 8]));
            check("R6 wrap on match", 32'(wrap4), 32'(i % 8 == 7));
            @(negedge clk);
        end

        // R8 terminal zero
        #1 rst_n = 1'b0; term4 = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R8 stays zero", 32'(q4), 32'h0);
            check("R8 wrap each cycle", 32'(wrap4), 32'h1);
            @(negedge clk);
        end

        // R3 full periods for 8 and 16 bits
        #1 rst_n = 1'b0; en4 = 1'b0; en8 = 1'b1; en16 = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        first0_8 = 0; first0_16 = 0; wrap8_at = -1; wrap16_at = -1; ones = 0;
        for (int n = 0; n <= 65535; n++) begin
            #1;
            if (n > 0 && q8 == 8'h00 && first0_8 == 0) first0_8 = n;
            if (n > 0 && q16 == 16'h0000 && first0_16 == 0) first0_16 = n;
            if (wrap8 && wrap8_at < 0) wrap8_at = n;
            if (wrap16 && wrap16_at < 0) wrap16_at = n;
            if (q8 == 8'hFF) ones++;
            if (q16 == 16'hFFFF) ones++;
            @(negedge clk);
        end
        check("R3 period 8-bit", 32'(first0_8), 32'd255);
        check("R3 period 16-bit", 32'(first0_16), 32'd65535);
        check("R6 wrap 8-bit", 32'(wrap8_at), 32'd254);
        check("R6 wrap 16-bit", 32'(wrap16_at), 32'd65534);
        check("R7 no all-ones", 32'(ones), 32'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule